// File: doc/BRIEF.md
# Sector Record Write Checker

This block sits behind a word deserializer on the write path of an emulated disk sector. While the host holds the write gate high, each synchronized 16-bit word is handed to the block. The block knows which record of the sector is being written: header, label or data. It stores each record word at the proper RAM location. It keeps a running XOR checksum and compares it against the checksum word that follows the record. When the sums disagree, it raises a sticky local error flag.

After the checksum of a header or label record, the host sends a short run of zero words. The block counts these words. When the run is complete, it pulses a request telling the deserializer to drop sync, so that the next record can be picked up at its own sync point. The RAM address is built from the cylinder, head and sector inputs and the word's position in the sector layout.

Top module: `sector_write_checker`

## Requirements
- R1: Record lengths are 2 words for the header, 8 for the label and 256 for the data record. The first record type is taken from `rec_type` in the cycle the block leaves idle, with the encoding 0 = header, 1 = label, 2 = data, and 3 treated as data. Later records in the same gate period advance internally in the order header, label, data.
- R2: `ram_addr` is the concatenation {cylinder, head, sector, offset}, with a 9-bit offset in the low bits. Header words use offsets 0 to 1, label words use 2 to 9 and data words use 10 to 265. The word offset counts up from the record's first word.
- R3: Each accepted record word gives `ram_we` high for exactly the cycle after the word is sampled, with `ram_wdata` equal to the word. Checksum words and trailer words never produce a write.
- R4: The checksum starts at 0x0151 at the beginning of every record and takes the XOR of each record word. The word after the last record word is compared with it. A mismatch sets `cksum_err` in the following cycle.
- R5: `cksum_err` stays set until `err_clr` is sampled high. If a mismatch and `err_clr` occur in the same cycle, the flag is set.
- R6: After the checksum of a header or label record, `drop_sync` pulses for one cycle following the fourth zero word. Nonzero words during the trailer are ignored and not counted. The next word after the pulse is the first word of the following record.
- R7: After the checksum of a data record, every further word is ignored until the write gate falls.
- R8: When `wr_gate` is sampled low, the block returns to idle and abandons any partial record. The next rise of the gate restarts at word 0 of the type then given, with a fresh seed.
- R9: After reset, `ram_we`, `drop_sync` and `cksum_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_gate | input | 1 | Host write gate |
| word_valid | input | 1 | A synchronized word is present this cycle |
| word_data | input | 16 | Synchronized word |
| rec_type | input | 2 | Record type at gate start (0 header, 1 label, 2/3 data) |
| sector | input | SEC_W | Current sector number |
| head | input | 1 | Head select from host |
| cylinder | input | CYL_W | Current cylinder |
| err_clr | input | 1 | Clears the checksum error flag |
| ram_addr | output | CYL_W+1+SEC_W+9 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write enable, one cycle per record word |
| drop_sync | output | 1 | One-cycle request to drop sync before the next record |
| cksum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
The bench checks the record boundaries. An off-by-one length would write the checksum word into RAM, or it would treat the last data word as the checksum. Either way the scoreboard sees an extra write or a missing write, and the address offsets shift. The bench sends only three trailer zeros and also places a nonzero word inside the trailer. A design that counted wrongly, or counted every trailer word, would pulse `drop_sync` early. The bench drops the gate in the middle of a label and restarts it. A design that kept its word count or checksum across the restart would write to the wrong offsets or flag a false error. Words sent after the data checksum must leave RAM untouched. A bad header checksum must keep the flag set until it is cleared.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int WORD_W    = 16;
  localparam logic [WORD_W-1:0] CKS_SEED = 16'h0151;
  localparam int HDR_WORDS = 2;
  localparam int LBL_WORDS = 8;
  localparam int DAT_WORDS = 256;
  localparam int SEC_WORDS = HDR_WORDS + LBL_WORDS + DAT_WORDS;
  localparam int OFF_W     = $clog2(SEC_WORDS);

  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    REC_HDR = 2'd0,
    REC_LBL = 2'd1,
    REC_DAT = 2'd2
  } rec_t;

  // Host code to record kind; the spare code falls onto the data record.
  function automatic rec_t decode_rec(input logic [1:0] code);
    case (code)
      2'd0:    return REC_HDR;
      2'd1:    return REC_LBL;
      default: return REC_DAT;
    endcase
  endfunction

  function automatic rec_t next_rec(input rec_t cur);
    case (cur)
      REC_HDR: return REC_LBL;
      default: return REC_DAT;
    endcase
  endfunction

  function automatic off_t rec_len(input rec_t cur);
    case (cur)
      REC_HDR: return off_t'(HDR_WORDS);
      REC_LBL: return off_t'(LBL_WORDS);
      default: return off_t'(DAT_WORDS);
    endcase
  endfunction

  // First word offset of each record within the sector layout.
  function automatic off_t rec_base(input rec_t cur);
    case (cur)
      REC_HDR: return off_t'(0);
      REC_LBL: return off_t'(HDR_WORDS);
      default: return off_t'(HDR_WORDS + LBL_WORDS);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] cks_step(input logic [WORD_W-1:0] acc,
                                                 input logic [WORD_W-1:0] w);
    return acc ^ w;
  endfunction
endpackage

// File: rtl/swc_cksum.sv
module swc_cksum
  import swc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              absorb,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum <= CKS_SEED;
    else if (restart) sum <= CKS_SEED;
    else if (absorb)  sum <= cks_step(sum, word);
  end
endmodule

// File: rtl/swc_addr_gen.sv
module swc_addr_gen
  import swc_pkg::*;
#(
  parameter int CYL_W = 8,
  parameter int SEC_W = 4,
  localparam int ADDR_W = CYL_W + 1 + SEC_W + OFF_W
) (
  input  logic [CYL_W-1:0]  cylinder,
  input  logic              head,
  input  logic [SEC_W-1:0]  sector,
  input  off_t              offset,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = {cylinder, head, sector, offset};
endmodule

// File: rtl/swc_seq.sv
module swc_seq
  import swc_pkg::*;
#(
  parameter int ZERO_RUN = 4,
  localparam int ZC_W = $clog2(ZERO_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gate,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [1:0]        rec_type,
  output logic              acc_word,
  output logic              cks_word,
  output logic              zero_last,
  output logic              start_rec,
  output off_t              offset
);
  typedef enum logic [2:0] {S_IDLE, S_REC, S_CHK, S_TRAIL, S_DONE} st_t;

  st_t             state;
  rec_t            cur;
  off_t            wcnt;
  logic [ZC_W-1:0] zcnt;
  logic            take;
  logic            zero_word;
  logic            last_word;

  always_comb begin
    take      = wr_gate && word_valid;
    acc_word  = take && (state == S_REC);
    cks_word  = take && (state == S_CHK);
    zero_word = take && (state == S_TRAIL) && (word_data == '0);
    zero_last = zero_word && (zcnt == ZC_W'(ZERO_RUN - 1));
    start_rec = (wr_gate && state == S_IDLE) || zero_last;
    last_word = acc_word && (wcnt == rec_len(cur) - off_t'(1));
    offset    = rec_base(cur) + wcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= REC_HDR;
      wcnt  <= '0;
      zcnt  <= '0;
    end else if (!wr_gate) begin
      state <= S_IDLE;
      wcnt  <= '0;
      zcnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_REC;
          cur   <= decode_rec(rec_type);
          wcnt  <= '0;
        end
        S_REC: if (acc_word) begin
          if (last_word) begin
            state <= S_CHK;
            wcnt  <= '0;
          end else begin
            wcnt  <= wcnt + off_t'(1);
          end
        end
        S_CHK: if (cks_word) begin
          zcnt  <= '0;
          state <= (cur == REC_DAT) ? S_DONE : S_TRAIL;
        end
        S_TRAIL: if (zero_word) begin
          if (zero_last) begin
            state <= S_REC;
            cur   <= next_rec(cur);
            wcnt  <= '0;
            zcnt  <= '0;
          end else begin
            zcnt  <= zcnt + ZC_W'(1);
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/sector_write_checker.sv
module sector_write_checker
  import swc_pkg::*;
#(
  parameter int CYL_W    = 8,
  parameter int SEC_W    = 4,
  parameter int ZERO_RUN = 4,
  localparam int ADDR_W  = CYL_W + 1 + SEC_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gate,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [1:0]        rec_type,
  input  logic [SEC_W-1:0]  sector,
  input  logic              head,
  input  logic [CYL_W-1:0]  cylinder,
  input  logic              err_clr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              drop_sync,
  output logic              cksum_err
);
  logic              acc_word;
  logic              cks_word;
  logic              zero_last;
  logic              start_rec;
  off_t              offset;
  logic [WORD_W-1:0] run_sum;
  logic [ADDR_W-1:0] addr_next;
  logic              cks_bad;

  swc_seq #(.ZERO_RUN(ZERO_RUN)) u_seq (
    .clk, .rst_n, .wr_gate, .word_valid, .word_data, .rec_type,
    .acc_word, .cks_word, .zero_last, .start_rec, .offset
  );

  swc_cksum u_cks (
    .clk, .rst_n, .restart(start_rec), .absorb(acc_word),
    .word(word_data), .sum(run_sum)
  );

  swc_addr_gen #(.CYL_W(CYL_W), .SEC_W(SEC_W)) u_addr (
    .cylinder, .head, .sector, .offset, .addr(addr_next)
  );

  always_comb cks_bad = cks_word && (word_data != run_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      drop_sync <= 1'b0;
      cksum_err <= 1'b0;
    end else begin
      ram_we    <= acc_word;
      drop_sync <= zero_last;
      if (acc_word) begin
        ram_addr  <= addr_next;
        ram_wdata <= word_data;
      end
      if (cks_bad)      cksum_err <= 1'b1;
      else if (err_clr) cksum_err <= 1'b0;
    end
  end
endmodule

// File: rtl/swc_checker.sv
module swc_checker
  import swc_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_gate,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              err_clr,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic              drop_sync,
  input logic              cksum_err,
  input logic              cks_word
);
  assert_write_follows_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(word_valid && wr_gate));

  assert_offset_in_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[OFF_W-1:0] < off_t'(SEC_WORDS)));

  assert_err_from_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cksum_err) |-> $past(cks_word));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cksum_err && !err_clr) |-> cksum_err);

  assert_drop_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_sync |-> $past(word_valid && word_data == '0));

  assert_drop_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_sync && ram_we));

  assert_gate_low_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_gate) |-> (!ram_we && !drop_sync));
endmodule

bind sector_write_checker swc_checker #(.ADDR_W(ADDR_W)) u_swc_chk (
  .clk, .rst_n, .wr_gate, .word_valid, .word_data, .err_clr,
  .ram_addr, .ram_we, .drop_sync, .cksum_err, .cks_word
);

// File: tb/tb_sector_write_checker.sv
module tb_sector_write_checker;
  localparam int PERIOD = 10;
  localparam int CYL_W  = 8;
  localparam int SEC_W  = 4;
  localparam int ADDR_W = CYL_W + 1 + SEC_W + 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_gate = 1'b0;
  logic word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic [1:0] rec_type = 2'd0;
  logic [SEC_W-1:0] sector = '0;
  logic head = 1'b0;
  logic [CYL_W-1:0] cylinder = '0;
  logic err_clr = 1'b0;
  logic [ADDR_W-1:0] ram_addr;
  logic [15:0] ram_wdata;
  logic ram_we, drop_sync, cksum_err;

  int total = 0;
  int bad = 0;
  int drops = 0;
  logic [ADDR_W+15:0] exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  sector_write_checker #(.CYL_W(CYL_W), .SEC_W(SEC_W), .ZERO_RUN(4)) dut (
    .clk, .rst_n, .wr_gate, .word_valid, .word_data, .rec_type, .sector,
    .head, .cylinder, .err_clr, .ram_addr, .ram_wdata, .ram_we,
    .drop_sync, .cksum_err
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every write (R2, R3), counts drop pulses.
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'(ram_addr), 0);
      end else begin
        logic [ADDR_W+15:0] e;
        e = exp_q.pop_front();
        check(ram_addr == e[ADDR_W+15:16], "R2 address", int'(ram_addr), int'(e[ADDR_W+15:16]));
        check(ram_wdata == e[15:0], "R3 data", int'(ram_wdata), int'(e[15:0]));
      end
    end
    if (rst_n && drop_sync) drops++;
  end

  function automatic int base_of(input int t);
    return (t == 0) ? 0 : (t == 1) ? 2 : 10;
  endfunction
  function automatic int len_of(input int t);
    return (t == 0) ? 2 : (t == 1) ? 8 : 256;
  endfunction

  task automatic send(input logic [15:0] w);
    word_valid = 1'b1;
    word_data  = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gate_on(input logic [1:0] t);
    rec_type = t;
    wr_gate  = 1'b1;
    @(negedge clk);
  endtask

  task automatic gate_off();
    wr_gate = 1'b0;
    idle(2);
  endtask

  // Driver: pushes expected writes, then sends words and checksum (R1, R4).
  task automatic record(input int t, input logic [15:0] key, input bit corrupt);
    logic [15:0] ck;
    ck = 16'h0151;
    for (int i = 0; i < len_of(t); i++) begin
      logic [15:0] w;
      w = key ^ 16'(i * 16'h1357) ^ 16'(i << 3);
      exp_q.push_back({cylinder, head, sector, 9'(base_of(t) + i), w});
      ck = ck ^ w;
      send(w);
    end
    send(corrupt ? (ck ^ 16'h0004) : ck);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) send(16'h0000);
  endtask

  task automatic drained(input string req);
    idle(2);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0;
    idle(3);
    // R9: reset state
    check(ram_we == 1'b0, "R9 ram_we", ram_we, 0);
    check(drop_sync == 1'b0, "R9 drop_sync", drop_sync, 0);
    check(cksum_err == 1'b0, "R9 cksum_err", cksum_err, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R6: full sector header->label->data
    cylinder = 8'd37; head = 1'b1; sector = 4'd5;
    gate_on(2'd0);
    record(0, 16'hA5A5, 1'b0);
    d0 = drops;
    zeros(3);
    idle(1);
    check(drops == d0, "R6 no drop after three zeros", drops, d0);
    zeros(1);
    idle(1);
    check(drops == d0 + 1, "R6 drop after fourth zero", drops, d0 + 1);
    record(1, 16'h3C3C, 1'b0);
    send(16'h1234);               // nonzero trailer word: ignored (R6)
    zeros(4);
    idle(1);
    check(drops == d0 + 2, "R6 drop after label trailer", drops, d0 + 2);
    record(2, 16'h0F0F, 1'b0);
    drained("R1 full sector writes");
    check(cksum_err == 1'b0, "R4 good sector no error", cksum_err, 0);

    // R7: words after data checksum are ignored
    send(16'hDEAD); send(16'h0000); zeros(4); send(16'hBEEF);
    idle(2);
    check(exp_q.size() == 0, "R7 no writes after data", exp_q.size(), 0);
    check(drops == d0 + 2, "R7 no drop after data", drops, d0 + 2);
    gate_off();

    // R4 R5: bad header checksum sets sticky flag
    cylinder = 8'd202; head = 1'b0; sector = 4'd11;
    gate_on(2'd0);
    record(0, 16'h7777, 1'b1);
    idle(1);
    check(cksum_err == 1'b1, "R4 mismatch sets flag", cksum_err, 1);
    zeros(4);
    record(1, 16'h1111, 1'b0);
    idle(3);
    check(cksum_err == 1'b1, "R5 flag sticky", cksum_err, 1);
    gate_off();
    check(cksum_err == 1'b1, "R5 flag survives gate drop", cksum_err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(cksum_err == 1'b0, "R5 clear", cksum_err, 0);
    drained("R3 bad-checksum record writes");

    // R8: gate drop mid-label, restart with fresh count and seed
    cylinder = 8'd1; head = 1'b1; sector = 4'd0;
    gate_on(2'd1);
    exp_q.push_back({cylinder, head, sector, 9'd2, 16'h4444});
    exp_q.push_back({cylinder, head, sector, 9'd3, 16'h5555});
    exp_q.push_back({cylinder, head, sector, 9'd4, 16'h6666});
    send(16'h4444); send(16'h5555); send(16'h6666);
    gate_off();
    send(16'h9999);               // gate low: ignored (R8)
    drained("R8 partial record only");
    gate_on(2'd1);
    record(1, 16'h2468, 1'b0);
    idle(1);
    check(cksum_err == 1'b0, "R8 fresh seed after restart", cksum_err, 0);
    drained("R8 restart offsets");
    gate_off();

    // R1: start directly at data record, spare code 3 as data
    cylinder = 8'd255; head = 1'b0; sector = 4'd15;
    gate_on(2'd3);
    record(2, 16'hFFFF, 1'b0);
    idle(1);
    check(cksum_err == 1'b0, "R1 data-first checksum", cksum_err, 0);
    drained("R1 data-first writes");
    gate_off();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule